// File: doc/BRIEF.md
# Width-Selectable FIFO with Level Monitor

This block is a 256-byte first-in first-out buffer placed between a 32-bit register port and a serial engine. One configuration word chooses how the shared byte storage is cut into entries: bytes, 16-bit halfwords or 32-bit words. The capacity is then 256, 128 or 64 entries. Each accepted push stores the low bits of the 32-bit input at the selected width. Each accepted pop presents the oldest entry in the low bits of the 32-bit output, with the upper bits zero.

A 10-bit status word packs three things: the entry count, a full flag and an empty flag. A programmable threshold gives a one-cycle event when the count reaches it. In fill direction (receive use) the count must rise to the threshold. In drain direction (transmit use) it must fall to it. An operation input gives software two commands: start/stop and flush.

Data moves over valid/ready handshakes. A push happens on a cycle where `in_valid` and `in_ready` are both high. A pop happens on a cycle where `out_valid` and `out_ready` are both high. `in_ready` is low while the FIFO is full or stopped. `out_valid` is low while it is empty or stopped. The two sides differ in one way. `in_valid` held against a low `in_ready` is counted as a refused push. `out_ready` raised against a low `out_valid` is counted as a refused pop. Each refused attempt is recorded in a sticky error flag, so sources and sinks should wait on the handshake before raising their request.

Top module: `wsel_fifo`

## Requirements
- R1: After reset the FIFO is stopped. The status word reads 0x200 (empty set, count 0). `in_ready`, `out_valid`, `thresh_evt` and `err_flag` are low.
- R2: `cfg_word[1:0]` selects the width: 0 means 8-bit entries, 1 means 16-bit entries, 2 means 32-bit entries, and 3 is treated as 2. Popped entries come out in push order, zero-extended in `out_data`.
- R3: The capacity is 256, 128 or 64 entries for widths 0, 1 and 2. At capacity the full flag is set and `in_ready` is low. The status word holds the low 8 bits of the entry count in [7:0], full in bit 8 and empty in bit 9. A full byte FIFO therefore reads 0x100.
- R4: An operation write with bit 1 set starts the FIFO. An operation write with bit 1 clear stops it. While the FIFO is stopped, `in_ready` and `out_valid` are low and the stored contents and count are kept.
- R5: An operation write with bit 0 set flushes the FIFO. The count and both pointers are zero in the next cycle. The flush overrides a push or pop in the same cycle, and it clears the error flag.
- R6: A refused push sets `err_flag` from the next cycle. A refused pop does the same. A refused access changes no contents and no count. The flag then stays set until a flush.
- R7: The width is taken from `cfg_word[1:0]` only on a cycle where the FIFO is empty and no push happens. A width change made while entries are held has no effect until the FIFO empties.
- R8: The threshold is `cfg_word[9:2]`. `thresh_evt` pulses for one cycle in the cycle after the transfer that moves the count onto the threshold. With `cfg_fill_dir`=1 this is a rise to the threshold. With `cfg_fill_dir`=0 it is a fall to it.
- R9: A push and a pop in the same cycle leave the count unchanged. The pop returns the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_we | input | 1 | Operation write strobe |
| op_wdata | input | 2 | Operation value: bit 0 flush, bit 1 run |
| cfg_word | input | 10 | [1:0] width code, [9:2] threshold |
| cfg_fill_dir | input | 1 | 1: event on rise to threshold, 0: on fall |
| in_valid | input | 1 | Push request |
| in_ready | output | 1 | FIFO can accept a push |
| in_data | input | 32 | Push data, low bits used |
| out_valid | output | 1 | An entry is available |
| out_ready | input | 1 | Pop request |
| out_data | output | 32 | Oldest entry, zero-extended |
| status | output | 10 | {empty, full, count[7:0]} |
| thresh_evt | output | 1 | Threshold-reached pulse |
| err_flag | output | 1 | Sticky refused-access flag |

## Verification
The assertions check several properties on every cycle: the count never exceeds the capacity of the current width, a flush empties the FIFO by the next cycle, the error flag stays set until a flush, the width register does not move while entries are held, a simultaneous push and pop keeps the count, and the threshold event never lasts two cycles. Some behaviour can only be shown by the bench's scenarios. This covers byte ordering and zero extension at each width, the status packing at full and empty, the exact cycle and direction of the threshold event, the flush winning over a push, and a width change deferred until the FIFO drains.

// File: rtl/fwf_pkg.sv
package fwf_pkg;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2,
    WID_RSVD = 2'd3
  } wid_e;

  // log2 of bytes per entry; the reserved code acts as a word
  function automatic logic [1:0] wid_shift(input logic [1:0] code);
    return (code == WID_RSVD) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/fwf_store.sv
module fwf_store #(
  parameter int BYTES = 256,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(BYTES)
) (
  input  logic               clk,
  input  logic [1:0]         shift,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic [8*LANES-1:0] wr_data,
  input  logic [PTR_W-1:0]   rd_ptr,
  output logic [8*LANES-1:0] rd_data
);

  logic [7:0]       mem [BYTES];
  logic [LANES-1:0] lane_en;

  always_comb begin
    for (int k = 0; k < LANES; k++)
      lane_en[k] = (32'(k) < (32'd1 << shift));
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < LANES; k++)
        if (lane_en[k]) mem[wr_ptr + PTR_W'(k)] <= wr_data[8*k +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
    assign rd_data[8*g +: 8] = lane_en[g] ? mem[rd_ptr + PTR_W'(g)] : 8'h00;
  end

endmodule

// File: rtl/fwf_ctrl.sv
module fwf_ctrl
  import fwf_pkg::*;
#(
  parameter int BYTES = 256,
  localparam int PTR_W = $clog2(BYTES),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_we,
  input  logic [1:0]       op_wdata,
  input  logic [1:0]       cfg_wid,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             push_fire,
  output logic             pop_fire,
  output logic             flush,
  output logic [1:0]       shift,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_nxt,
  output logic             full,
  output logic             empty,
  output logic             err
);

  localparam logic [LVL_W-1:0] BYTES_L = LVL_W'(BYTES);

  logic             run_q;
  logic [1:0]       wid_q;
  logic [LVL_W-1:0] cap;
  logic [PTR_W-1:0] step;
  logic             refused;

  assign shift   = wid_q;
  assign cap     = BYTES_L >> wid_q;
  assign step    = PTR_W'(1) << wid_q;
  assign full    = (level == cap);
  assign empty   = (level == '0);
  assign flush   = op_we & op_wdata[0];

  assign in_ready  = run_q & ~full;
  assign out_valid = run_q & ~empty;
  assign push_fire = in_valid & in_ready & ~flush;
  assign pop_fire  = out_ready & out_valid & ~flush;
  assign refused   = (in_valid & ~in_ready) | (out_ready & ~out_valid);

  always_comb begin
    if (flush)                       level_nxt = '0;
    else if (push_fire && !pop_fire) level_nxt = level + LVL_W'(1);
    else if (pop_fire && !push_fire) level_nxt = level - LVL_W'(1);
    else                             level_nxt = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wid_q  <= 2'd0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      err    <= 1'b0;
    end else begin
      if (op_we) run_q <= op_wdata[1];
      level <= level_nxt;
      err   <= flush ? 1'b0 : (err | refused);
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_fire) wr_ptr <= wr_ptr + step;
        if (pop_fire)  rd_ptr <= rd_ptr + step;
      end
      if (empty && !push_fire) wid_q <= wid_shift(cfg_wid);
    end
  end

  // R3
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= cap);

  // R5
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && op_wdata[0]) |=> (level == '0) && (rd_ptr == wr_ptr));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(op_we && op_wdata[0])) |=> err);

  // R7
  wid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |=> $stable(wid_q));

  // R9
  both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> $stable(level));

endmodule

// File: rtl/fwf_thresh.sv
module fwf_thresh #(
  parameter int LVL_W = 9,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_dir,
  input  logic [THR_W-1:0] thr,
  input  logic [LVL_W-1:0] lvl_cur,
  input  logic [LVL_W-1:0] lvl_nxt,
  input  logic             flush,
  output logic             evt
);

  logic [LVL_W-1:0] thr_ext;
  logic             rise_hit;
  logic             fall_hit;

  assign thr_ext  = LVL_W'(thr);
  assign rise_hit = (lvl_cur < thr_ext) && (lvl_nxt >= thr_ext);
  assign fall_hit = (lvl_cur > thr_ext) && (lvl_nxt <= thr_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= ~flush & (fill_dir ? rise_hit : fall_hit);
  end

  // R8
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

endmodule

// File: rtl/wsel_fifo.sv
module wsel_fifo #(
  parameter int STORE_BYTES = 256,
  parameter int DATA_W      = 32,
  parameter int THR_W       = 8,
  localparam int LANES = DATA_W / 8,
  localparam int PTR_W = $clog2(STORE_BYTES),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_we,
  input  logic [1:0]        op_wdata,
  input  logic [THR_W+1:0]  cfg_word,
  input  logic              cfg_fill_dir,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [THR_W+1:0]  status,
  output logic              thresh_evt,
  output logic              err_flag
);

  logic             push_fire, pop_fire, flush, full, empty;
  logic [1:0]       shift;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level, level_nxt;

  fwf_ctrl #(.BYTES(STORE_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_we     (op_we),
    .op_wdata  (op_wdata),
    .cfg_wid   (cfg_word[1:0]),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .flush     (flush),
    .shift     (shift),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .level     (level),
    .level_nxt (level_nxt),
    .full      (full),
    .empty     (empty),
    .err       (err_flag)
  );

  fwf_store #(.BYTES(STORE_BYTES), .LANES(LANES)) u_store (
    .clk     (clk),
    .shift   (shift),
    .wr_en   (push_fire),
    .wr_ptr  (wr_ptr),
    .wr_data (in_data),
    .rd_ptr  (rd_ptr),
    .rd_data (out_data)
  );

  fwf_thresh #(.LVL_W(LVL_W), .THR_W(THR_W)) u_thresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_dir (cfg_fill_dir),
    .thr      (cfg_word[THR_W+1:2]),
    .lvl_cur  (level),
    .lvl_nxt  (level_nxt),
    .flush    (flush),
    .evt      (thresh_evt)
  );

  assign status = {empty, full, level[THR_W-1:0]};

  // R1
  empty_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[THR_W+1] |-> !out_valid);

endmodule

// File: tb/tb_wsel_fifo.sv
module tb_wsel_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_we = 1'b0;
  logic [1:0]  op_wdata = 2'b00;
  logic [9:0]  cfg_word = '0;
  logic        cfg_fill_dir = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [9:0]  status;
  logic        thresh_evt;
  logic        err_flag;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic last_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsel_fifo dut (
    .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_wdata(op_wdata),
    .cfg_word(cfg_word), .cfg_fill_dir(cfg_fill_dir),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .status(status), .thresh_evt(thresh_evt), .err_flag(err_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] v);
    op_we = 1'b1; op_wdata = v;
    @(negedge clk);
    op_we = 1'b0;
  endtask

  task automatic setcfg(input logic [1:0] w, input logic [7:0] thr, input logic dir);
    cfg_word = {thr, w}; cfg_fill_dir = dir;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    last_evt = thresh_evt;
  endtask

  task automatic pop(output logic [31:0] v);
    out_ready = 1'b1; v = out_data;
    @(negedge clk);
    out_ready = 1'b0;
    last_evt = thresh_evt;
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(status), 32'h200);
    chk("R1 in_ready", 32'(in_ready), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 err", 32'(err_flag), 0);
    chk("R1 evt", 32'(thresh_evt), 0);
  endtask

  task automatic t_byte_full();
    logic [31:0] v;
    int bad = 0;
    op(2'b11); setcfg(2'd0, 8'd200, 1'b1);
    for (int i = 0; i < 256; i++) push(32'hFFFF_FF00 | 32'(i));
    chk("R3 byte full status", 32'(status), 32'h100);
    chk("R3 byte full in_ready", 32'(in_ready), 0);
    for (int i = 0; i < 256; i++) begin
      pop(v);
      if (v !== 32'(i & 8'hFF)) bad++;
    end
    chk("R2 byte order zero-ext mismatches", 32'(bad), 0);
    chk("R3 byte drained status", 32'(status), 32'h200);
  endtask

  task automatic t_half();
    logic [31:0] v;
    op(2'b11); setcfg(2'd1, 8'd100, 1'b1);
    push(32'h1234_ABCD); push(32'h0000_5678);
    chk("R3 half level", 32'(status), 32'h002);
    pop(v); chk("R2 half first", v, 32'h0000_ABCD);
    pop(v); chk("R2 half second", v, 32'h0000_5678);
  endtask

  task automatic t_word_full();
    logic [31:0] v;
    int bad = 0;
    op(2'b11); setcfg(2'd2, 8'd100, 1'b1);
    for (int i = 0; i < 64; i++) push(32'h0101_0101 * 32'(i) ^ 32'hA5A5_0000);
    chk("R3 word full status", 32'(status), 32'h140);
    chk("R3 word full in_ready", 32'(in_ready), 0);
    for (int i = 0; i < 64; i++) begin
      pop(v);
      if (v !== (32'h0101_0101 * 32'(i) ^ 32'hA5A5_0000)) bad++;
    end
    chk("R2 word order mismatches", 32'(bad), 0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    op(2'b11); setcfg(2'd0, 8'd100, 1'b1);
    push(32'h5A);
    op(2'b00);
    chk("R4 stopped in_ready", 32'(in_ready), 0);
    chk("R4 stopped out_valid", 32'(out_valid), 0);
    chk("R4 stopped keeps level", 32'(status), 32'h001);
    op(2'b10);
    chk("R4 restarted out_valid", 32'(out_valid), 1);
    pop(v); chk("R4 data kept", v, 32'h5A);
  endtask

  task automatic t_flush_prio();
    op(2'b11); setcfg(2'd0, 8'd100, 1'b1);
    push(32'h01); push(32'h02);
    op_we = 1'b1; op_wdata = 2'b11; in_valid = 1'b1; in_data = 32'h03;
    @(negedge clk);
    op_we = 1'b0; in_valid = 1'b0;
    chk("R5 flush beats push", 32'(status), 32'h200);
    chk("R5 flush err clear", 32'(err_flag), 0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    op(2'b11);
    pop(v);
    chk("R6 pop on empty sets err", 32'(err_flag), 1);
    chk("R6 pop on empty level", 32'(status), 32'h200);
    op(2'b10);
    chk("R6 err sticky", 32'(err_flag), 1);
    op(2'b00);
    push(32'h77);
    chk("R6 push when stopped ignored", 32'(status), 32'h200);
    op(2'b11);
    chk("R5 flush clears err", 32'(err_flag), 0);
    setcfg(2'd0, 8'd100, 1'b1);
    for (int i = 0; i < 256; i++) push(32'(i));
    push(32'h99);
    chk("R6 push on full sets err", 32'(err_flag), 1);
    chk("R6 push on full level", 32'(status), 32'h100);
    op(2'b11);
  endtask

  task automatic t_width_lock();
    logic [31:0] v;
    op(2'b11); setcfg(2'd0, 8'd100, 1'b1);
    push(32'h11);
    setcfg(2'd2, 8'd100, 1'b1);
    push(32'hAABB_CCDD);
    pop(v); chk("R7 old width first", v, 32'h11);
    pop(v); chk("R7 width change ignored while held", v, 32'hDD);
    setcfg(2'd2, 8'd100, 1'b1);
    push(32'hAABB_CCDD);
    pop(v); chk("R7 width applied once empty", v, 32'hAABB_CCDD);
    setcfg(2'd3, 8'd100, 1'b1);
    push(32'hCAFE_F00D);
    pop(v); chk("R2 code 3 acts as word", v, 32'hCAFE_F00D);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    logic [4:0] pat;
    op(2'b11); setcfg(2'd0, 8'd3, 1'b1);
    for (int i = 0; i < 5; i++) begin push(32'(i)); pat[i] = last_evt; end
    chk("R8 fill event on reaching 3", 32'(pat), 32'b00100);
    setcfg(2'd0, 8'd2, 1'b0);
    chk("R8 no event on config change", 32'(thresh_evt), 0);
    for (int i = 0; i < 5; i++) begin pop(v); pat[i] = last_evt; end
    chk("R8 drain event on falling to 2", 32'(pat), 32'b00100);
  endtask

  task automatic t_simul();
    logic [31:0] v;
    op(2'b11); setcfg(2'd1, 8'd100, 1'b1);
    push(32'h1111);
    in_valid = 1'b1; in_data = 32'h2222; out_ready = 1'b1; v = out_data;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    chk("R9 simultaneous pop oldest", v, 32'h1111);
    chk("R9 simultaneous level kept", 32'(status), 32'h001);
    pop(v); chk("R9 second entry", v, 32'h2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_full();
    t_half();
    t_word_full();
    t_stop();
    t_flush_prio();
    t_err();
    t_width_lock();
    t_thresh();
    t_simul();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule